// File: doc/BRIEF.md
# TLB Random Replacement Counter

This block picks the victim slot in a 64-entry unified translation buffer when software loads a new translation. It keeps a 6-bit replacement counter. The counter steps forward once for every cycle in which the buffer is looked up. A programmable 6-bit boundary lets software keep the upper entries out of the replacement rotation. The counter sends the victim index to the array, and it also drives a one-hot write-enable vector while a load is in progress.

Both fields sit in a single 16-bit control word, and software can read and write that word. A write replaces both fields in one cycle. The counter field occupies bits [5:0] and the boundary field occupies bits [13:8]. Every other bit reads as zero. A load strobe never moves the counter, so several loads issued with no lookup between them all target the same slot.

Top module: `tlb_repl_ctr`

## Requirements
- R1: After reset is asserted (rst_n low), the counter and the boundary both read 0, so cfg_rdata_o = 0 and repl_idx_o = 0.
- R2: In a cycle with tlb_access_i high, tlb_load_i low and cfg_we_i low, the counter goes up by one on the next clock edge, unless R3 or R4 applies.
- R3: When the boundary is nonzero and the counter equals it, an advancing cycle (as in R2) sets the counter to 0.
- R4: With a boundary of 0 the counter steps through all 64 values. From 63 it always goes to 0, whatever the boundary holds.
- R5: Software may write a counter value above a nonzero boundary. The counter then keeps advancing past the boundary up to 63, and only after that wraps to 0.
- R6: In a cycle with tlb_load_i high, the counter does not change, even when tlb_access_i is also high.
- R7: When cfg_we_i is high, cfg_wdata_i[5:0] goes into the counter and cfg_wdata_i[13:8] goes into the boundary on the next edge. This write wins over an access in the same cycle. Bits [7:6] and [15:14] always read 0.
- R8: fill_we_o is zero when tlb_load_i is low. When tlb_load_i is high, exactly one bit is set, and that bit is the one selected by the current counter value.
- R9: In a cycle with both tlb_access_i and cfg_we_i low, the counter and the boundary keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-on or manual) |
| tlb_access_i | input | 1 | Single-cycle pulse, one per buffer lookup |
| tlb_load_i | input | 1 | Software load of a buffer entry is in progress |
| cfg_we_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 16 | Control word write data |
| cfg_rdata_o | output | 16 | Control word read data |
| repl_idx_o | output | 6 | Current replacement index (the counter value) |
| fill_we_o | output | 64 | One-hot entry write enable during a load |

## Verification
The bench runs the counter up to a nonzero boundary. A design that ignored the boundary would read boundary+1 where 0 is expected. A design that wrapped only on an exact compare, after the counter was written above the boundary, would hold at 63 or jump straight back. The bench also runs the counter freely from 0 with a boundary of 0, because a design that used the zero boundary as a compare value would stay at 0. It drives a load together with an access, and a write together with an access. These catch a design that lets a load advance the counter, or that lets the increment overwrite the written value.

// File: rtl/tlbrc_pkg.sv
package tlbrc_pkg;
  parameter int unsigned CNT_W   = 6;
  parameter int unsigned REG_W   = 16;
  parameter int unsigned BND_LSB = 8;
  localparam int unsigned N_ENT  = 1 << CNT_W;
endpackage

// File: rtl/tlbrc_next.sv
module tlbrc_next #(
  parameter int unsigned CW = tlbrc_pkg::CNT_W
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] bnd_i,
  output logic [CW-1:0] nxt_o
);
  localparam logic [CW-1:0] TOP = '1;
  logic at_top, at_bnd;

  always_comb begin
    at_top = (cnt_i == TOP);
    at_bnd = (bnd_i != '0) && (cnt_i == bnd_i);
    if (at_top || at_bnd) nxt_o = '0;
    else                  nxt_o = CW'(cnt_i + 1'b1);
  end
endmodule

// File: rtl/tlbrc_regs.sv
module tlbrc_regs #(
  parameter int unsigned CW      = tlbrc_pkg::CNT_W,
  parameter int unsigned RW      = tlbrc_pkg::REG_W,
  parameter int unsigned BND_LSB = tlbrc_pkg::BND_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [RW-1:0] wdata_i,
  input  logic          adv_i,
  input  logic [CW-1:0] nxt_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] bnd_o,
  output logic [RW-1:0] rdata_o
);
  logic unused_wbits;
  assign unused_wbits = ^wdata_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
      bnd_o <= '0;
    end else if (we_i) begin
      cnt_o <= wdata_i[CW-1:0];
      bnd_o <= wdata_i[BND_LSB +: CW];
    end else if (adv_i) begin
      cnt_o <= nxt_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[CW-1:0]       = cnt_o;
    rdata_o[BND_LSB +: CW] = bnd_o;
  end
endmodule

// File: rtl/tlbrc_fill_dec.sv
module tlbrc_fill_dec #(
  parameter int unsigned CW = tlbrc_pkg::CNT_W,
  localparam int unsigned NE = 1 << CW
) (
  input  logic          en_i,
  input  logic [CW-1:0] idx_i,
  output logic [NE-1:0] we_o
);
  for (genvar gi = 0; gi < NE; gi++) begin : g_ent
    assign we_o[gi] = en_i && (idx_i == CW'(gi));
  end
endmodule

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr #(
  parameter int unsigned CW      = tlbrc_pkg::CNT_W,
  parameter int unsigned RW      = tlbrc_pkg::REG_W,
  parameter int unsigned BND_LSB = tlbrc_pkg::BND_LSB,
  localparam int unsigned NE     = 1 << CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tlb_access_i,
  input  logic          tlb_load_i,
  input  logic          cfg_we_i,
  input  logic [RW-1:0] cfg_wdata_i,
  output logic [RW-1:0] cfg_rdata_o,
  output logic [CW-1:0] repl_idx_o,
  output logic [NE-1:0] fill_we_o
);
  logic [CW-1:0] cnt_q, bnd_q, cnt_nxt;
  logic          adv;

  // a load cycle never advances the counter, even with a lookup in flight
  assign adv = tlb_access_i & ~tlb_load_i;

  tlbrc_next #(.CW(CW)) next_i (
    .cnt_i(cnt_q), .bnd_i(bnd_q), .nxt_o(cnt_nxt)
  );

  tlbrc_regs #(.CW(CW), .RW(RW), .BND_LSB(BND_LSB)) regs_i (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .adv_i(adv), .nxt_i(cnt_nxt), .cnt_o(cnt_q), .bnd_o(bnd_q),
    .rdata_o(cfg_rdata_o)
  );

  tlbrc_fill_dec #(.CW(CW)) dec_i (
    .en_i(tlb_load_i), .idx_i(cnt_q), .we_o(fill_we_o)
  );

  assign repl_idx_o = cnt_q;
endmodule

// File: rtl/tlb_repl_ctr_chk.sv
module tlb_repl_ctr_chk #(
  parameter int unsigned CW      = tlbrc_pkg::CNT_W,
  parameter int unsigned RW      = tlbrc_pkg::REG_W,
  parameter int unsigned BND_LSB = tlbrc_pkg::BND_LSB,
  localparam int unsigned NE     = 1 << CW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tlb_access_i,
  input logic          tlb_load_i,
  input logic          cfg_we_i,
  input logic [RW-1:0] cfg_wdata_i,
  input logic [RW-1:0] cfg_rdata_o,
  input logic [CW-1:0] repl_idx_o,
  input logic [NE-1:0] fill_we_o
);
  localparam logic [CW-1:0] TOP = '1;
  logic [RW-1:0] fld_mask;
  logic [CW-1:0] bnd;
  logic          step;

  always_comb begin
    fld_mask = '0;
    fld_mask[CW-1:0]        = '1;
    fld_mask[BND_LSB +: CW] = '1;
  end
  assign bnd  = cfg_rdata_o[BND_LSB +: CW];
  assign step = tlb_access_i && !tlb_load_i && !cfg_we_i;

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && repl_idx_o != TOP && !(bnd != '0 && repl_idx_o == bnd))
    |=> repl_idx_o == CW'($past(repl_idx_o) + 1'b1));

  a_r3_bound_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && bnd != '0 && repl_idx_o == bnd) |=> repl_idx_o == '0);

  a_r4_top_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && repl_idx_o == TOP) |=> repl_idx_o == '0);

  a_r6_load_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_load_i && !cfg_we_i) |=> $stable(repl_idx_o));

  a_r7_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> cfg_rdata_o == ($past(cfg_wdata_i) & fld_mask));

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata_o & ~fld_mask) == '0);

  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_we_o) && (tlb_load_i ? fill_we_o[repl_idx_o] : fill_we_o == '0));

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tlb_access_i && !cfg_we_i) |=> $stable(cfg_rdata_o));
endmodule

bind tlb_repl_ctr tlb_repl_ctr_chk #(.CW(CW), .RW(RW), .BND_LSB(BND_LSB)) chk_i (
  .clk(clk), .rst_n(rst_n), .tlb_access_i(tlb_access_i), .tlb_load_i(tlb_load_i),
  .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
  .repl_idx_o(repl_idx_o), .fill_we_o(fill_we_o)
);

// File: tb/tlb_repl_ctr_tb_top.sv
module tlb_repl_ctr_tb_top;
  localparam int CW = 6;
  localparam int NE = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc = 1'b0, ld = 1'b0, we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [CW-1:0] idx;
  logic [NE-1:0] fill;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [CW-1:0] e_idx;
    logic [15:0]   e_rd;
    string         tag;
  } exp_t;
  exp_t sb[$];

  logic [CW-1:0] m_cnt = '0;
  logic [CW-1:0] m_bnd = '0;

  always #10 clk = ~clk;

  tlb_repl_ctr dut_i (
    .clk(clk), .rst_n(rst_n), .tlb_access_i(acc), .tlb_load_i(ld),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .repl_idx_o(idx), .fill_we_o(fill)
  );

  function automatic logic [15:0] rd_of(logic [CW-1:0] c, logic [CW-1:0] b);
    logic [15:0] r;
    r = '0;
    r[5:0]  = c;
    r[13:8] = b;
    return r;
  endfunction

  // one cycle of stimulus; model follows the requirements
  task automatic op(bit a, bit l, bit w, logic [5:0] wc, logic [5:0] wb, string tag);
    logic [NE-1:0] e_fill;
    exp_t e;
    @(negedge clk);
    acc = a; ld = l; we = w;
    wdata = '0;
    wdata[5:0] = wc;
    wdata[13:8] = wb;
    #1;
    e_fill = l ? (64'd1 << m_cnt) : '0;
    total++;
    if (fill !== e_fill) begin
      bad++;
      $display("FAIL R8 fill_we act=%h exp=%h", fill, e_fill);
    end
    if (w) begin
      m_cnt = wc;
      m_bnd = wb;
    end else if (a && !l) begin
      if (m_cnt == 6'd63) m_cnt = '0;
      else if (m_bnd != 0 && m_cnt == m_bnd) m_cnt = '0;
      else m_cnt = m_cnt + 6'd1;
    end
    e.e_idx = m_cnt;
    e.e_rd  = rd_of(m_cnt, m_bnd);
    e.tag   = tag;
    sb.push_back(e);
  endtask

  // monitor: compare one result per clock, in the high phase
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (idx !== e.e_idx || rdata !== e.e_rd) begin
          bad++;
          $display("FAIL %s idx/rdata act=%0d/%h exp=%0d/%h", e.tag, idx, rdata, e.e_idx, e.e_rd);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (idx !== 0 || rdata !== 0) begin
      bad++;
      $display("FAIL R1 reset act=%0d/%h exp=0/0000", idx, rdata);
    end
    @(negedge clk);
    rst_n = 1'b1;

    op(0, 0, 0, 0, 0, "R9");
    op(0, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 5; i++) op(1, 0, 0, 0, 0, "R2");
    op(0, 1, 0, 0, 0, "R6");
    op(1, 1, 0, 0, 0, "R6");
    op(0, 1, 0, 0, 0, "R8");
    op(0, 0, 1, 6, 8, "R7");
    for (int i = 0; i < 3; i++) op(1, 0, 0, 0, 0, "R3");
    op(1, 0, 0, 0, 0, "R3");
    op(1, 0, 1, 3, 8, "R7");
    op(0, 0, 1, 60, 8, "R7");
    for (int i = 0; i < 5; i++) op(1, 0, 0, 0, 0, "R5");
    op(0, 0, 1, 0, 1, "R7");
    for (int i = 0; i < 4; i++) op(1, 0, 0, 0, 0, "R3");
    op(0, 0, 1, 62, 0, "R7");
    for (int i = 0; i < 2; i++) op(1, 0, 0, 0, 0, "R4");
    for (int i = 0; i < 64; i++) op(1, 0, 0, 0, 0, "R4");
    op(0, 0, 1, 63, 63, "R7");
    op(1, 0, 0, 0, 0, "R4");
    op(0, 1, 0, 0, 0, "R8");
    op(0, 0, 0, 0, 0, "R9");
    op(0, 0, 0, 0, 0, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule